// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the arithmetic and logic stage of a 32-bit load/store core. Each clock cycle it accepts one data-processing operation: a 4-bit operation code, a first operand, a second operand that an earlier stage has already shifted, the carry produced by that shifter, the current flag word, a flag-update request and a 4-bit condition code. One cycle later it presents the result, a write strobe for the destination register and the flag word that the core should hold next.

The condition code is tested against the incoming flags. When the test fails, the operation still uses its cycle but writes nothing and leaves the flags untouched. Four operation codes are compare-only: they can only update flags and never raise the write strobe. The register file, the operand shifter, multiplication and memory access belong to other blocks.

The flag word is 4 bits wide, with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0, on both `flags_i` and `flags_o`.

Top module: `dpx_exec_unit`

## Requirements
- R1: The logical codes give these results: 0000 A AND B, 0001 A XOR B, 1100 A OR B, 1101 B, 1110 A AND NOT B, 1111 NOT B.
- R2: The arithmetic codes give these results modulo 2^32: 0010 A-B, 0011 B-A, 0100 A+B, 0101 A+B+C, 0110 A-B+C-1, 0111 B-A+C-1. Here C is the incoming carry flag.
- R3: Codes 1000 (A AND B), 1001 (A XOR B), 1010 (A-B) and 1011 (A+B) never raise `rd_we_o`. When flag update is requested and the condition passes, they set the flags from their value.
- R4: When `set_flags_i` is 0, `flags_o` equals the `flags_i` presented with the operation.
- R5: On a flag update, N is bit 31 of the operation's value, and Z is 1 exactly when all 32 bits of the value are zero.
- R6: On a flag update by an add or subtract code, C is the carry out of bit 31. For subtraction this means 1 when no borrow occurs. V is 1 when the signed result of the operation performed overflows 32 bits.
- R7: On a flag update by a logical code, C takes `sh_carry_i` and V keeps its incoming value.
- R8: The condition passes as follows: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, 1111 never.
- R9: When the condition fails, `rd_we_o` is 0 and `flags_o` equals `flags_i`, whatever the code and `set_flags_i`. Non-compare codes whose condition passes raise `rd_we_o`.
- R10: All outputs are registered and appear on the clock edge after the inputs are sampled. A synchronous active-low reset drives `result_o`, `rd_we_o` and `flags_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Shifted second operand B |
| sh_carry_i | input | 1 | Carry out of the operand shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| set_flags_i | input | 1 | Request a flag update |
| cond_i | input | 4 | Condition code |
| result_o | output | 32 | Operation value, registered |
| rd_we_o | output | 1 | Destination write strobe, registered |
| flags_o | output | 4 | Next flags {N,Z,C,V}, registered |

## Verification
Two functions can act in the same cycle: the condition gate and the flag update of a compare-only code. Either one could be the one that decides `flags_o`. The bench provokes this by issuing compare codes with `set_flags_i` high under every condition and every flag pattern, so that roughly half of these operations fail their test. A failing operation is judged correct only if `flags_o` returns the incoming flags unchanged and `rd_we_o` stays low. A passing one must carry the compare's computed flags and still not write.

// File: rtl/dpx_pkg.sv
// Package dpx_pkg
// Shared operation codes, condition codes and the flag word layout for the
// data-processing execute unit. Assumes the flag word is ordered {N,Z,C,V}.
package dpx_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'b0000,
        OP_XOR   = 4'b0001,
        OP_SUB   = 4'b0010,
        OP_RSUB  = 4'b0011,
        OP_ADD   = 4'b0100,
        OP_ADDC  = 4'b0101,
        OP_SUBC  = 4'b0110,
        OP_RSUBC = 4'b0111,
        OP_TAND  = 4'b1000,
        OP_TXOR  = 4'b1001,
        OP_CSUB  = 4'b1010,
        OP_CADD  = 4'b1011,
        OP_OR    = 4'b1100,
        OP_PASS  = 4'b1101,
        OP_CLR   = 4'b1110,
        OP_NOT   = 4'b1111
    } dp_op_e;

    typedef enum logic [3:0] {
        CC_ZS = 4'h0, CC_ZC = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_NS = 4'h4, CC_NC = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_UGT = 4'h8, CC_ULE = 4'h9, CC_SGE = 4'hA, CC_SLT = 4'hB,
        CC_SGT = 4'hC, CC_SLE = 4'hD, CC_ALL = 4'hE, CC_NONE = 4'hF
    } dp_cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dpx_cond_eval.sv
// Module dpx_cond_eval
// Decides whether an operation executes by testing its condition code
// against the incoming flags. Purely combinational; code 1111 never passes.
module dpx_cond_eval
    import dpx_pkg::*;
(
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);

    // Evaluate the condition code against the flag word.
    always_comb begin
        unique case (dp_cond_e'(cond_i))
            CC_ZS:   pass_o = flags_i.z;
            CC_ZC:   pass_o = !flags_i.z;
            CC_CS:   pass_o = flags_i.c;
            CC_CC:   pass_o = !flags_i.c;
            CC_NS:   pass_o = flags_i.n;
            CC_NC:   pass_o = !flags_i.n;
            CC_VS:   pass_o = flags_i.v;
            CC_VC:   pass_o = !flags_i.v;
            CC_UGT:  pass_o = flags_i.c && !flags_i.z;
            CC_ULE:  pass_o = !flags_i.c || flags_i.z;
            CC_SGE:  pass_o = (flags_i.n == flags_i.v);
            CC_SLT:  pass_o = (flags_i.n != flags_i.v);
            CC_SGT:  pass_o = !flags_i.z && (flags_i.n == flags_i.v);
            CC_SLE:  pass_o = flags_i.z || (flags_i.n != flags_i.v);
            CC_ALL:  pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dpx_alu_core.sv
// Module dpx_alu_core
// Computes the value of one data-processing operation and the full flag
// word it would produce. All add/subtract forms share one adder by
// choosing the adder inputs and carry-in. Assumes operand B is already
// shifted and that sh_carry_i is the shifter's carry out.
module dpx_alu_core
    import dpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              sh_carry_i,
    input  nzcv_t             flags_i,
    output logic [DATA_W-1:0] value_o,
    output nzcv_t             flags_o
);

    localparam int MSB = DATA_W - 1;

    logic              is_arith;
    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W:0]   add_sum;
    logic [DATA_W-1:0] logic_val;
    logic              ovf;

    // Select adder inputs and carry-in for each add/subtract form.
    always_comb begin
        is_arith = 1'b1;
        add_x    = opa_i;
        add_y    = opb_i;
        add_cin  = 1'b0;
        unique case (dp_op_e'(op_i))
            OP_SUB, OP_CSUB: begin add_y = ~opb_i; add_cin = 1'b1; end
            OP_RSUB:  begin add_x = opb_i; add_y = ~opa_i; add_cin = 1'b1; end
            OP_ADD, OP_CADD: add_cin = 1'b0;
            OP_ADDC:  add_cin = flags_i.c;
            OP_SUBC:  begin add_y = ~opb_i; add_cin = flags_i.c; end
            OP_RSUBC: begin add_x = opb_i; add_y = ~opa_i; add_cin = flags_i.c; end
            default:  is_arith = 1'b0;
        endcase
    end

    // Shared adder with carry out and signed-overflow detection.
    always_comb begin
        add_sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};
        ovf     = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
    end

    // Bitwise operation values.
    always_comb begin
        unique case (dp_op_e'(op_i))
            OP_AND, OP_TAND: logic_val = opa_i & opb_i;
            OP_XOR, OP_TXOR: logic_val = opa_i ^ opb_i;
            OP_OR:           logic_val = opa_i | opb_i;
            OP_PASS:         logic_val = opb_i;
            OP_CLR:          logic_val = opa_i & ~opb_i;
            OP_NOT:          logic_val = ~opb_i;
            default:         logic_val = '0;
        endcase
    end

    // Merge value and derive the candidate flag word.
    always_comb begin
        value_o   = is_arith ? add_sum[MSB:0] : logic_val;
        flags_o.n = value_o[MSB];
        flags_o.z = (value_o == '0);
        flags_o.c = is_arith ? add_sum[DATA_W] : sh_carry_i;
        flags_o.v = is_arith ? ovf : flags_i.v;
    end

endmodule

// File: rtl/dpx_exec_unit.sv
// Module dpx_exec_unit
// Top of the data-processing execute unit. Combines the condition gate and
// the ALU core and registers result, write strobe and next flags, so that
// outputs follow inputs by one clock. Assumes a synchronous active-low reset.
module dpx_exec_unit
    import dpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              sh_carry_i,
    input  logic [3:0]        flags_i,
    input  logic              set_flags_i,
    input  logic [3:0]        cond_i,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_we_o,
    output logic [3:0]        flags_o
);

    localparam int MSB = DATA_W - 1;

    nzcv_t             flags_cur;
    nzcv_t             flags_calc;
    logic [DATA_W-1:0] value;
    logic              cond_pass;
    logic              cmp_only;

    assign flags_cur = nzcv_t'(flags_i);
    assign cmp_only  = (op_i[3:2] == 2'b10);

    dpx_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_cur),
        .pass_o  (cond_pass)
    );

    dpx_alu_core #(.DATA_W(DATA_W)) u_core (
        .op_i       (op_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .sh_carry_i (sh_carry_i),
        .flags_i    (flags_cur),
        .value_o    (value),
        .flags_o    (flags_calc)
    );

    // Register result, gated write strobe and next flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            rd_we_o  <= 1'b0;
            flags_o  <= '0;
        end else begin
            result_o <= value;
            rd_we_o  <= cond_pass && !cmp_only;
            flags_o  <= (cond_pass && set_flags_i) ? flags_calc : flags_i;
        end
    end

    // R3: compare-only codes never write the destination.
    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] == 2'b10) |=> !rd_we_o);

    // R4: without a flag-update request the flags pass through.
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> (flags_o == $past(flags_i)));

    // R9: a failed condition writes nothing and keeps the flags.
    a_r9_fail_noop: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |=> (!rd_we_o && flags_o == $past(flags_i)));

    // R8: condition 1111 never executes.
    a_r8_never: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'hF) |=> !rd_we_o);

    // R5: updated N and Z agree with the registered value.
    a_r5_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_pass && set_flags_i) |=>
            (flags_o[3] == result_o[MSB] && flags_o[2] == (result_o == '0)));

endmodule

// File: tb/dpx_exec_unit_tb.sv
module dpx_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic        shc;
    logic [3:0]  fin;
    logic        sf;
    logic [3:0]  cc;
    logic [31:0] result;
    logic        we;
    logic [3:0]  fout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    dpx_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .sh_carry_i(shc), .flags_i(fin), .set_flags_i(sf), .cond_i(cc),
        .result_o(result), .rd_we_o(we), .flags_o(fout)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h cond=%h sf=%0d fin=%h : actual %h expected %h",
                     req, op, cc, sf, fin, act, exp);
        end
    endtask

    function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy & !z;    4'h9: return !cy | z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z & (n == v);
            4'hD: return z | (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference from the requirements, using wide signed/unsigned arithmetic.
    task automatic model(output logic [31:0] r, output logic w, output logic [3:0] f);
        longint ua, ub, us, sa, sb, ss;
        logic   ci, arith, c, v;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ci = fin[1];
        arith = 1'b1;
        us = 0; ss = 0; r = '0;
        case (op)
            4'h2, 4'hA: begin us = ua - ub;          ss = sa - sb; end
            4'h3:       begin us = ub - ua;          ss = sb - sa; end
            4'h4, 4'hB: begin us = ua + ub;          ss = sa + sb; end
            4'h5:       begin us = ua + ub + ci;     ss = sa + sb + ci; end
            4'h6:       begin us = ua - ub - !ci;    ss = sa - sb - !ci; end
            4'h7:       begin us = ub - ua - !ci;    ss = sb - sa - !ci; end
            default:    arith = 1'b0;
        endcase
        if (arith) begin
            r = us[31:0];
            if (op == 4'h4 || op == 4'h5 || op == 4'hB) c = (us >= 64'sh1_0000_0000);
            else c = (us >= 0);
            v = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
        end else begin
            case (op)
                4'h0, 4'h8: r = a & b;
                4'h1, 4'h9: r = a ^ b;
                4'hC:       r = a | b;
                4'hD:       r = b;
                4'hE:       r = a & ~b;
                default:    r = ~b;
            endcase
            c = shc;
            v = fin[0];
        end
        w = cond_ref(cc, fin) && !(op >= 4'h8 && op <= 4'hB);
        f = (cond_ref(cc, fin) && sf) ? {r[31], r == 32'h0, c, v} : fin;
    endtask

    task automatic apply();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic s, input logic [3:0] f, input logic set, input logic [3:0] c);
        @(negedge clk);
        op = o; a = x; b = y; shc = s; fin = f; sf = set; cc = c;
    endtask

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // R10: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        drive(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b1, 4'hF, 1'b1, 4'hE);
        apply();
        apply();
        check("R10 reset result", 64'(result), 64'h0);
        check("R10 reset we", 64'(we), 64'h0);
        check("R10 reset flags", 64'(fout), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R5 R6 R7 R4: every code with and without flag update.
    task automatic t_all_ops();
        logic [31:0] pa [10];
        logic [31:0] pb [10];
        logic [31:0] er; logic ew; logic [3:0] ef;
        pa = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000,
               32'h1234_5678, 32'h5, 32'h0, 32'hF0F0_0F0F, 32'h1};
        pb = '{32'h0, 32'h1, 32'h1, 32'h8000_0000, 32'h1,
               32'h1234_5678, 32'h9, 32'hFFFF_FFFF, 32'h0FF0_F00F, 32'h7FFF_FFFF};
        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 14; p++) begin
                    logic [31:0] x, y;
                    next_rand();
                    if (p < 10) begin x = pa[p]; y = pb[p]; end
                    else begin x = lfsr; next_rand(); y = lfsr; end
                    drive(4'(o), x, y, lfsr[3], 4'(p + o), 1'(s), 4'hE);
                    model(er, ew, ef);
                    apply();
                    check(o < 8 && o > 1 ? "R2 value" : "R1 value", 64'(result), 64'(er));
                    check(o[3:2] == 2'b10 ? "R3 write strobe" : "R9 write strobe", 64'(we), 64'(ew));
                    check(s == 0 ? "R4 flags held" :
                          (o > 1 && o < 12 && !(o == 8 || o == 9)) ? "R6 flags" : "R7 R5 flags",
                          64'(fout), 64'(ef));
                end
            end
        end
    endtask

    // R8 R9: all conditions against all flag patterns, incl. compare with update.
    task automatic t_conditions();
        logic [31:0] er; logic ew; logic [3:0] ef;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(4'h4, 32'h10, 32'h20, 1'b0, 4'(f), 1'b1, 4'(c));
                model(er, ew, ef);
                apply();
                check("R8 condition gate", 64'(we), 64'(ew));
                check("R9 flags under condition", 64'(fout), 64'(ef));
                drive(4'hA, 32'h3, 32'h3, 1'b1, 4'(f), 1'b1, 4'(c));
                model(er, ew, ef);
                apply();
                check("R3 compare no write", 64'(we), 64'h0);
                check("R9 compare flags vs condition", 64'(fout), 64'(ef));
            end
        end
    endtask

    // R10: back-to-back operations each land one clock later.
    task automatic t_pipeline();
        drive(4'hD, 32'h0, 32'hAAAA_0001, 1'b0, 4'h0, 1'b0, 4'hE);
        @(posedge clk); #2;
        check("R10 first latency", 64'(result), 64'hAAAA_0001);
        op = 4'hD; b = 32'h5555_0002;
        check("R10 output stable before edge", 64'(result), 64'hAAAA_0001);
        @(posedge clk); #2;
        check("R10 second latency", 64'(result), 64'h5555_0002);
    endtask

    initial begin
        op = '0; a = '0; b = '0; shc = 0; fin = '0; sf = 0; cc = 4'hE; rst_n = 1'b0;
        t_reset();
        t_all_ops();
        t_conditions();
        t_pipeline();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule